// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit keeps a 64-bit graphics status word. Its upper half serves as a byte-permutation mask: one 4-bit selector for each output byte. It accepts two commands. The mask-add command sums two 64-bit operands and returns the sum. It also places the low 32 bits of that sum into the mask half of the status word.

The shuffle command builds a 64-bit result. It takes each output byte from a 16-byte pool made of the two operands, and the stored selector for that byte names which pool byte to use. A separate load port writes the whole status word, and the status word can be read at any time.

A small controller runs two named states:
- **ST_IDLE**: no result pending.
- **ST_RESULT**: a result was captured on the previous edge.

The transitions are:
- **T_ISSUE**: ST_IDLE to ST_RESULT, taken when a command is valid.
- **T_CHAIN**: ST_RESULT to ST_RESULT, taken when another command is valid.
- **T_DRAIN**: ST_RESULT to ST_IDLE, taken when no command is valid.

The result-valid output is high exactly in ST_RESULT.

Top module: `bsu_top`

## Requirements
- R1: After reset is released, the status word reads zero, the result reads zero and result-valid is low.
- R2: A mask-add command (cmd_sel = 0) gives res_data = op_a + op_b modulo 2^64, one clock after the command, with res_valid high in that cycle.
- R3: A mask-add command writes sum[31:0] into status bits [63:32] and leaves status bits [31:0] unchanged.
- R4: A shuffle command (cmd_sel = 1) sets result byte i (bits [8i+7:8i]) from selector i = status bits [32+4i+3:32+4i]. A selector value v of 0 to 7 picks op_a byte v. A shuffle leaves the status word unchanged.
- R5: In a shuffle, a selector value v of 8 to 15 picks op_b byte v-8.
- R6: When no mask-add is issued in a cycle, gsr_ld_en = 1 writes gsr_ld_data into the whole status word on that edge.
- R7: When a mask-add and a load fall in the same cycle, the load is discarded completely, and R3 alone decides the new status word.
- R8: A shuffle issued in the cycle right after a mask-add uses the mask written by that mask-add.
- R9: res_valid is high for exactly one cycle per command, and stays high through back-to-back commands. In a cycle with no command, res_valid is low, res_data holds its last value and the status word is unchanged unless a load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_sel | input | 1 | 0 = mask-add, 1 = shuffle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| gsr_ld_en | input | 1 | Write the whole status word |
| gsr_ld_data | input | 64 | Status word value to load |
| res_data | output | 64 | Registered command result |
| res_valid | output | 1 | One-cycle result strobe |
| gsr_q | output | 64 | Current status word |

## Verification
The mask-add write and the status load port can target the status word on the same edge. The bench first loads a known lower half. It then issues a mask-add together with a load of a different pattern. The next read of the status word must show the new mask above the previously loaded lower half, with no bits from the discarded load. A second contention case issues a shuffle in the cycle right after a mask-add, and the result is judged against the freshly written mask rather than the older one.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    typedef enum logic {
        CMD_MASKADD = 1'b0,
        CMD_SHUFFLE = 1'b1
    } bsu_cmd_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } bsu_state_e;
endpackage

// File: rtl/bsu_gsr.sv
module bsu_gsr #(
    parameter int DATA_W    = 64,
    parameter int MASK_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [MASK_BITS-1:0] mask_din,
    input  logic                 ld_en,
    input  logic [DATA_W-1:0]    ld_data,
    output logic [DATA_W-1:0]    gsr_q
);
    localparam int LOW_W = DATA_W - MASK_BITS;

    // the mask-add write outranks the full-word load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gsr_q <= '0;
        end else if (mask_we) begin
            gsr_q <= {mask_din, gsr_q[LOW_W-1:0]};
        end else if (ld_en) begin
            gsr_q <= ld_data;
        end
    end
endmodule

// File: rtl/bsu_shuffle.sv
module bsu_shuffle #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]                                   src_a,
    input  logic [DATA_W-1:0]                                   src_b,
    input  logic [(DATA_W/LANE_W)*$clog2(2*(DATA_W/LANE_W))-1:0] sel_mask,
    output logic [DATA_W-1:0]                                   dout
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int SEL_W = $clog2(2 * LANES);

    logic [2*DATA_W-1:0] pool;
    assign pool = {src_b, src_a};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0] pick;
        assign pick = sel_mask[i*SEL_W +: SEL_W];
        assign dout[i*LANE_W +: LANE_W] = pool[int'(pick)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
    import bsu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_sel,
    input  logic [DATA_W-1:0] sum_val,
    input  logic [DATA_W-1:0] shuf_val,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid
);
    bsu_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cmd_valid ? ST_RESULT : ST_IDLE;   // T_ISSUE
            ST_RESULT: state_d = cmd_valid ? ST_RESULT : ST_IDLE;   // T_CHAIN / T_DRAIN
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (cmd_valid) begin
            res_data <= (bsu_cmd_e'(cmd_sel) == CMD_SHUFFLE) ? shuf_val : sum_val;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import bsu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              gsr_ld_en,
    input  logic [DATA_W-1:0] gsr_ld_data,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] gsr_q
);
    localparam int LANES     = DATA_W / LANE_W;
    localparam int SEL_W     = $clog2(2 * LANES);
    localparam int MASK_BITS = LANES * SEL_W;

    logic [DATA_W-1:0] sum_val;
    logic [DATA_W-1:0] shuf_val;
    logic              mask_we;

    assign sum_val = op_a + op_b;
    assign mask_we = cmd_valid && (bsu_cmd_e'(cmd_sel) == CMD_MASKADD);

    bsu_gsr #(.DATA_W(DATA_W), .MASK_BITS(MASK_BITS)) u_gsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (mask_we),
        .mask_din (sum_val[MASK_BITS-1:0]),
        .ld_en    (gsr_ld_en),
        .ld_data  (gsr_ld_data),
        .gsr_q    (gsr_q)
    );

    bsu_shuffle #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_shuf (
        .src_a    (op_a),
        .src_b    (op_b),
        .sel_mask (gsr_q[DATA_W-1 -: MASK_BITS]),
        .dout     (shuf_val)
    );

    bsu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_sel   (cmd_sel),
        .sum_val   (sum_val),
        .shuf_val  (shuf_val),
        .res_data  (res_data),
        .res_valid (res_valid)
    );
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_sel,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              gsr_ld_en,
    input logic [DATA_W-1:0] gsr_ld_data,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic [DATA_W-1:0] gsr_q
);
    localparam int HALF = DATA_W / 2;

    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_sel) |=> (res_valid && res_data == $past(op_a) + $past(op_b)));

    p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_sel) |=>
        (gsr_q[DATA_W-1:HALF] == HALF'($past(op_a) + $past(op_b))
         && gsr_q[HALF-1:0] == $past(gsr_q[HALF-1:0])));

    p_shuffle_keeps_gsr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_sel && !gsr_ld_en) |=> $stable(gsr_q));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gsr_ld_en && !(cmd_valid && !cmd_sel)) |=> (gsr_q == $past(gsr_ld_data)));

    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!res_valid && $stable(res_data)));

    p_valid_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> res_valid);

    p_idle_gsr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !gsr_ld_en) |=> $stable(gsr_q));
endmodule

bind bsu_top bsu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_sel     (cmd_sel),
    .op_a        (op_a),
    .op_b        (op_b),
    .gsr_ld_en   (gsr_ld_en),
    .gsr_ld_data (gsr_ld_data),
    .res_data    (res_data),
    .res_valid   (res_valid),
    .gsr_q       (gsr_q)
);

// File: tb/bsu_top_tb.sv
module bsu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_sel, gsr_ld_en;
    logic [63:0] op_a, op_b, gsr_ld_data;
    logic [63:0] res_data, gsr_q;
    logic        res_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bsu_top u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .op_a(op_a), .op_b(op_b), .gsr_ld_en(gsr_ld_en), .gsr_ld_data(gsr_ld_data),
        .res_data(res_data), .res_valid(res_valid), .gsr_q(gsr_q)
    );

    function automatic logic [63:0] shuf_ref(input logic [31:0] m, input logic [63:0] a,
                                             input logic [63:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            int v = int'(m[4*i +: 4]);
            r[8*i +: 8] = (v < 8) ? a[8*v +: 8] : b[8*(v-8) +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        cmd_valid = 0; cmd_sel = 0; op_a = '0; op_b = '0;
        gsr_ld_en = 0; gsr_ld_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [63:0] v);
        idle_in(); gsr_ld_en = 1; gsr_ld_data = v;
        step(); idle_in();
    endtask

    task automatic t_reset();
        idle_in(); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 gsr", gsr_q, 64'h0);
        chk("R1 res_data", res_data, 64'h0);
        chk("R1 res_valid", {63'h0, res_valid}, 64'h0);
    endtask

    task automatic t_load();
        do_load(64'h1111_2222_3333_4444);
        chk("R6 load", gsr_q, 64'h1111_2222_3333_4444);
    endtask

    task automatic t_maskadd_wrap();
        idle_in(); cmd_valid = 1; cmd_sel = 0;
        op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h2;
        step(); idle_in();
        chk("R2 sum wrap", res_data, 64'h1);
        chk("R2 valid", {63'h0, res_valid}, 64'h1);
        chk("R3 gsr", gsr_q, 64'h0000_0001_3333_4444);
        step();
        chk("R9 valid drops", {63'h0, res_valid}, 64'h0);
        chk("R9 data held", res_data, 64'h1);
        chk("R9 gsr stable", gsr_q, 64'h0000_0001_3333_4444);
    endtask

    task automatic t_collision();
        idle_in(); cmd_valid = 1; cmd_sel = 0;
        op_a = 64'h10; op_b = 64'h20;
        gsr_ld_en = 1; gsr_ld_data = 64'hAAAA_AAAA_AAAA_AAAA;
        step(); idle_in();
        chk("R7 collision", gsr_q, 64'h0000_0030_3333_4444);
        chk("R7 sum", res_data, 64'h30);
    endtask

    task automatic t_shuffle(input string req, input logic [31:0] m,
                             input logic [63:0] a, input logic [63:0] b);
        do_load({m, 32'h5A5A_0F0F});
        cmd_valid = 1; cmd_sel = 1; op_a = a; op_b = b;
        step(); idle_in();
        chk(req, res_data, shuf_ref(m, a, b));
        chk("R4 gsr kept", gsr_q, {m, 32'h5A5A_0F0F});
    endtask

    task automatic t_chain();
        do_load(64'h7654_3210_0000_0000);
        cmd_valid = 1; cmd_sel = 0; op_a = 64'hFEDC_BA00; op_b = 64'h98;
        step();
        chk("R8 first valid", {63'h0, res_valid}, 64'h1);
        cmd_valid = 1; cmd_sel = 1;
        op_a = 64'h1122_3344_5566_7788; op_b = 64'h0123_4567_89AB_CDEF;
        step(); idle_in();
        chk("R8 new mask used", res_data, 64'h0123_4567_89AB_CDEF);
        chk("R9 valid chained", {63'h0, res_valid}, 64'h1);
        step();
        chk("R9 valid ends", {63'h0, res_valid}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_maskadd_wrap();
        t_collision();
        t_shuffle("R4 identity from a", 32'h7654_3210,
                  64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);
        t_shuffle("R5 all from b", 32'hFEDC_BA98,
                  64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);
        t_shuffle("R5 mixed lanes", 32'h0F3C_8A17,
                  64'hDEAD_BEEF_CAFE_F00D, 64'h0102_0304_0506_0708);
        t_shuffle("R4 broadcast", 32'h3333_3333,
                  64'h0011_2233_4455_6677, 64'h0);
        t_chain();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule